// File: doc/BRIEF.md
# Serial Port Frame Sync Monitor

This block watches the frame sync line of a synchronous serial port and decides, once per bit clock, when a word transfer begins and how long it lasts. It runs on the fast system clock and does nothing except on cycles where the bit-clock enable is high. It samples the sync line, the mode controls and the word length only on those cycles. From the sync line and the programmed word length it produces a word-start strobe, a word-active flag and a last-bit flag. A serializer elsewhere in the port uses these to shift data.

The block also enforces the framing rules and records violations in two sticky flags. A sync that is held too wide in early-sync mode is a violation. So is a sync that drops before the final bit in late-sync mode, and so is a sync edge that arrives while a word is still in flight. A premature sync during the final word of a transmit block also raises a transmit underflow flag. Mode inputs control the rules. One relaxes the width and late-drop rules. One makes premature syncs be dropped instead of restarting the word. One suppresses the underflow report. One requires a fresh sync edge after the port is enabled.

Top module: `fsync_monitor`

## Requirements
- R1: After reset, and after any bit-clock tick with `port_en` low, `word_start`, `word_active` and `last_bit` are low. While the port is disabled, the two error flags keep their value.
- R2: A sync event is a tick where `fs_in` is 1 and was 0 at the previous tick. An accepted event raises `word_start` for one bit period and `word_active` for exactly L bit periods, where L is the word length. `last_bit` is high during the final one of those periods.
- R3: With `edge_start`=1 and `ext_sync`=1, a sync that is already high when the port is enabled does not start a word. A start needs `fs_in` sampled low at a tick while enabled, followed by a rising sample.
- R4: With `ext_sync`=0, `edge_start` has no effect, so a sync high at enable starts a word on the first enabled tick.
- R5: With `ext_sync`=1, `late_sync`=0 and `err_relax`=0, `fs_in` still high one tick after the tick that started a word sets `sync_err`.
- R6: With `ext_sync`=1, `late_sync`=1 and `err_relax`=0, `fs_in` low at any tick of an active word before its last bit sets `sync_err`.
- R7: With `err_relax`=1, the rules of R5 and R6 are off, and only a premature sync sets `sync_err`.
- R8: A premature sync is a sync event while a word is active and not in its last bit. It always sets `sync_err`. With `drop_premature`=0 it restarts the word with a new `word_start`.
- R9: With `drop_premature`=1, a premature sync starts no word, and the current word runs to its full length.
- R10: A premature sync while `tx_last_word`=1 sets `tx_underflow`, unless `uf_relax`=1.
- R11: `sync_err` and `tx_underflow` are sticky. They clear at a tick with `err_clr`=1. A new violation in the same tick wins over the clear.
- R12: Outputs change only in the clock cycle after a cycle with `bclk_en` high.
- R13: A `word_len` value below 3 acts as 3, and a value above 32 acts as 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bclk_en | input | 1 | Bit-clock enable; one tick per serial bit |
| port_en | input | 1 | Port enable; low forces idle |
| fs_in | input | 1 | Frame sync line, active high |
| word_len | input | 6 | Word length in bits (clamped to 3..32) |
| ext_sync | input | 1 | 1 = sync driven from outside the port |
| late_sync | input | 1 | 1 = late-sync framing (sync spans the word) |
| edge_start | input | 1 | 1 = require a fresh sync edge after enable |
| err_relax | input | 1 | 1 = only premature syncs are errors |
| drop_premature | input | 1 | 1 = premature syncs start no word |
| uf_relax | input | 1 | 1 = no underflow report for premature syncs |
| tx_last_word | input | 1 | Current word is the last of a transmit block |
| err_clr | input | 1 | Clears both sticky flags at a tick |
| word_start | output | 1 | High during the first bit of a word |
| word_active | output | 1 | High while a word is in progress |
| last_bit | output | 1 | High during the final bit of a word |
| sync_err | output | 1 | Sticky frame sync error |
| tx_underflow | output | 1 | Sticky transmit underflow from a premature sync |

## Verification
Two pairs of functions can fall in the same tick. The first is a premature sync and an `err_clr`. The bench schedules the sync edge exactly one bit short of a 16-bit word and holds `err_clr` high for that same tick. It then expects `sync_err` to read 1 afterwards, and to read 0 only after a later clear with no violation. The second is a word's last bit and the next sync edge. A sync period of 15 bits on a 16-bit word makes every second edge land inside the word. The bench counts `word_start` pulses against the drop setting to check whether each edge restarted the word or was ignored.

// File: rtl/sfm_pkg.sv
`timescale 1ns/1ps
package sfm_pkg;
    // Edge tracker state: last sampled sync level and the rearm flag
    typedef struct packed {
        logic prev;
        logic armed;
    } sfm_edge_t;

    // Sticky error flags
    typedef struct packed {
        logic sync_err;
        logic tx_uf;
    } sfm_flags_t;
endpackage

// File: rtl/sfm_sync_detect.sv
`timescale 1ns/1ps
module sfm_sync_detect
    import sfm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic port_en,
    input  logic fs_in,
    input  logic edge_gate,
    output logic sync_evt
);
    sfm_edge_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            if (!port_en) begin
                st_d.prev  = 1'b0;
                st_d.armed = 1'b0;
            end else begin
                st_d.prev  = fs_in;
                st_d.armed = st_q.armed | ~fs_in;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // rising sample; in edge-qualified mode an inactive sample must come first
    assign sync_evt = tick & port_en & fs_in & ~st_q.prev & (st_q.armed | ~edge_gate);

    // R3: a disabled tick drops the arming so a held sync cannot start a word
    p_rearm_on_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !port_en) |=> !st_q.armed);
endmodule

// File: rtl/sfm_word_ctr.sv
`timescale 1ns/1ps
module sfm_word_ctr #(
    parameter int unsigned MAX_LEN = 32,
    parameter int unsigned MIN_LEN = 3,
    parameter int unsigned LW      = 6,
    parameter int unsigned CW      = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          port_en,
    input  logic          sync_evt,
    input  logic          drop_premature,
    input  logic [LW-1:0] word_len,
    output logic          word_start,
    output logic          word_active,
    output logic          last_bit,
    output logic          premature
);
    localparam logic [LW-1:0] MIN_W = LW'(MIN_LEN);
    localparam logic [LW-1:0] MAX_W = LW'(MAX_LEN);

    typedef struct packed {
        logic          active;
        logic          start;
        logic [CW-1:0] cnt;
    } ctr_t;

    ctr_t          st_d, st_q;
    logic [LW-1:0] len_eff;
    logic [LW-1:0] len_m1;
    logic          accept;

    always_comb begin
        if (word_len < MIN_W)      len_eff = MIN_W;
        else if (word_len > MAX_W) len_eff = MAX_W;
        else                       len_eff = word_len;
        len_m1 = len_eff - LW'(1);
    end

    assign premature = sync_evt & st_q.active & (st_q.cnt != '0);
    assign accept    = sync_evt & ~(premature & drop_premature);

    always_comb begin
        st_d = st_q;
        if (tick) begin
            if (!port_en) begin
                st_d = '0;
            end else if (accept) begin
                st_d.active = 1'b1;
                st_d.start  = 1'b1;
                st_d.cnt    = len_m1[CW-1:0];
            end else begin
                st_d.start = 1'b0;
                if (st_q.active) begin
                    if (st_q.cnt == '0) st_d.active = 1'b0;
                    else                st_d.cnt    = st_q.cnt - CW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_start  = st_q.start;
    assign word_active = st_q.active;
    assign last_bit    = st_q.active & (st_q.cnt == '0);

    // R1: a disabled tick empties the counter state
    p_idle_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !port_en) |=> (st_q == '0));
    // R2: a word opens with more than one bit left
    p_start_not_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.start |-> (st_q.active && st_q.cnt != '0));
    // R8: an undropped premature sync restarts the word
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && premature && !drop_premature) |=> st_q.start);
    // R9: a dropped premature sync leaves the word running
    p_drop_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && premature && drop_premature) |=> (!st_q.start && st_q.active));
    // R12: nothing moves without a bit tick
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(st_q));
    // R13: the loaded count never falls below the minimum word
    p_min_len_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && accept) |=> (st_q.cnt >= CW'(MIN_LEN - 1)));
endmodule

// File: rtl/sfm_err_track.sv
`timescale 1ns/1ps
module sfm_err_track
    import sfm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic err_clr,
    input  logic premature,
    input  logic wide_viol,
    input  logic late_viol,
    input  logic tx_last_word,
    input  logic uf_relax,
    output logic sync_err,
    output logic tx_underflow
);
    sfm_flags_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (tick) begin
            if (err_clr) fl_d = '0;
            if (premature || wide_viol || late_viol) fl_d.sync_err = 1'b1;
            if (premature && tx_last_word && !uf_relax) fl_d.tx_uf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign sync_err     = fl_q.sync_err;
    assign tx_underflow = fl_q.tx_uf;

    // R11: the error flag only drops on a clear tick
    p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_q.sync_err && !(tick && err_clr)) |=> fl_q.sync_err);
    // R11: a clear with no violation in the same tick empties the flag
    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && err_clr && !premature && !wide_viol && !late_viol) |=> !fl_q.sync_err);
    // R10: with the relax control set the underflow flag cannot rise
    p_uf_relax_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && uf_relax && !fl_q.tx_uf) |=> !fl_q.tx_uf);
endmodule

// File: rtl/fsync_monitor.sv
`timescale 1ns/1ps
module fsync_monitor #(
    parameter int unsigned MAX_LEN = 32,
    parameter int unsigned MIN_LEN = 3,
    localparam int unsigned LW     = $clog2(MAX_LEN + 1),
    localparam int unsigned CW     = $clog2(MAX_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bclk_en,
    input  logic          port_en,
    input  logic          fs_in,
    input  logic [LW-1:0] word_len,
    input  logic          ext_sync,
    input  logic          late_sync,
    input  logic          edge_start,
    input  logic          err_relax,
    input  logic          drop_premature,
    input  logic          uf_relax,
    input  logic          tx_last_word,
    input  logic          err_clr,
    output logic          word_start,
    output logic          word_active,
    output logic          last_bit,
    output logic          sync_err,
    output logic          tx_underflow
);
    logic sync_evt;
    logic premature;
    logic edge_gate;
    logic wide_viol;
    logic late_viol;

    assign edge_gate = edge_start & ext_sync;

    sfm_sync_detect u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (bclk_en),
        .port_en   (port_en),
        .fs_in     (fs_in),
        .edge_gate (edge_gate),
        .sync_evt  (sync_evt)
    );

    sfm_word_ctr #(
        .MAX_LEN (MAX_LEN),
        .MIN_LEN (MIN_LEN),
        .LW      (LW),
        .CW      (CW)
    ) u_ctr (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick           (bclk_en),
        .port_en        (port_en),
        .sync_evt       (sync_evt),
        .drop_premature (drop_premature),
        .word_len       (word_len),
        .word_start     (word_start),
        .word_active    (word_active),
        .last_bit       (last_bit),
        .premature      (premature)
    );

    // framing rules only apply to a sync driven from outside
    assign wide_viol = bclk_en & port_en & ext_sync & ~late_sync & ~err_relax
                     & fs_in & word_start;
    assign late_viol = bclk_en & port_en & ext_sync & late_sync & ~err_relax
                     & word_active & ~last_bit & ~fs_in;

    sfm_err_track u_err (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (bclk_en),
        .err_clr      (err_clr),
        .premature    (premature),
        .wide_viol    (wide_viol),
        .late_viol    (late_viol),
        .tx_last_word (tx_last_word),
        .uf_relax     (uf_relax),
        .sync_err     (sync_err),
        .tx_underflow (tx_underflow)
    );

    // R7: relaxed rules leave only premature syncs as a source of errors
    p_relax_only_premature_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_en && err_relax && !premature && !sync_err) |=> !sync_err);
    // R2: the final-bit flag never shows outside a word
    p_last_inside_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        last_bit |-> (word_active && !word_start));
endmodule

// File: tb/fsync_monitor_bench.sv
`timescale 1ns/1ps
module fsync_monitor_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bclk_en = 1'b0, port_en = 1'b0, fs_in = 1'b0;
    logic [5:0] word_len = 6'd8;
    logic       ext_sync = 1'b1, late_sync = 1'b0, edge_start = 1'b0, err_relax = 1'b0;
    logic       drop_premature = 1'b0, uf_relax = 1'b0, tx_last_word = 1'b0, err_clr = 1'b0;
    logic       word_start, word_active, last_bit, sync_err, tx_underflow;

    int total = 0, bad = 0;
    int starts = 0, act_clks = 0;
    bit ws_prev = 1'b0, done = 1'b0;
    string phase = "reset";

    always #2 clk = ~clk; // 250 MHz

    fsync_monitor u_fsync_monitor (
        .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en), .port_en(port_en), .fs_in(fs_in),
        .word_len(word_len), .ext_sync(ext_sync), .late_sync(late_sync),
        .edge_start(edge_start), .err_relax(err_relax), .drop_premature(drop_premature),
        .uf_relax(uf_relax), .tx_last_word(tx_last_word), .err_clr(err_clr),
        .word_start(word_start), .word_active(word_active), .last_bit(last_bit),
        .sync_err(sync_err), .tx_underflow(tx_underflow)
    );

    // ---------------- behavioural reference ----------------
    int m_left = 0;
    bit m_active = 0, m_start = 0, m_prev = 0, m_armed = 0, m_err = 0, m_uf = 0;

    function automatic int eff_len(input int n);
        if (n < 3)  return 3;
        if (n > 32) return 32;
        return n;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_left = 0; m_active = 0; m_start = 0; m_prev = 0; m_armed = 0; m_err = 0; m_uf = 0;
        end else if (bclk_en) begin
            if (err_clr) begin m_err = 0; m_uf = 0; end
            if (!port_en) begin
                m_active = 0; m_start = 0; m_left = 0; m_prev = 0; m_armed = 0;
            end else begin
                bit ev, prem, wide, latev;
                ev    = fs_in && !m_prev && (!(edge_start && ext_sync) || m_armed);
                prem  = ev && m_active && (m_left > 0);
                wide  = ext_sync && !late_sync && !err_relax && fs_in && m_start;
                latev = ext_sync && late_sync && !err_relax && m_active && (m_left > 0) && !fs_in;
                if (prem || wide || latev) m_err = 1;
                if (prem && tx_last_word && !uf_relax) m_uf = 1;
                if (ev && !(prem && drop_premature)) begin
                    m_active = 1; m_start = 1; m_left = eff_len(int'(word_len)) - 1;
                end else begin
                    m_start = 0;
                    if (m_active) begin
                        if (m_left == 0) m_active = 0;
                        else m_left--;
                    end
                end
                m_prev  = fs_in;
                m_armed = m_armed || !fs_in;
            end
        end
    end

    // per-cycle comparison and event counters
    always @(negedge clk) begin
        if (!done) begin
            logic [4:0] act, exp;
            act = {word_start, word_active, last_bit, sync_err, tx_underflow};
            exp = {m_start, m_active, m_active && (m_left == 0), m_err, m_uf};
            total++;
            if (act !== exp) begin
                bad++;
                $display("FAIL R2/R12 cycle compare [%s]: actual=%b expected=%b", phase, act, exp);
            end
            if (word_start && !ws_prev) starts++;
            if (word_active) act_clks++;
            ws_prev = word_start;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one serial bit: tick cycle then a quiet cycle
    task automatic tb_bit(input logic f);
        fs_in = f; bclk_en = 1'b1;
        @(negedge clk);
        bclk_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tb_bit(1'b0);
    endtask

    task automatic zero_counts();
        starts = 0; act_clks = 0;
    endtask

    task automatic clear_flags();
        err_clr = 1'b1; tb_bit(1'b0); err_clr = 1'b0;
    endtask

    task automatic sync_train(input int period, input int count);
        for (int k = 0; k < period * (count - 1) + 1; k++) tb_bit((k % period) == 0);
        idle(20);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check({word_start, word_active, last_bit, sync_err, tx_underflow} == 5'b0,
              "R1 reset outputs", int'({word_start, word_active, last_bit, sync_err, tx_underflow}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        port_en = 1'b1;
        idle(2);

        phase = "R2"; zero_counts();
        tb_bit(1'b1); idle(12);
        check(starts == 1, "R2 start count", starts, 1);
        check(act_clks == 16, "R2 active cycles L=8", act_clks, 16);

        phase = "R13"; word_len = 6'd1; zero_counts();
        tb_bit(1'b1); idle(8);
        check(act_clks == 6, "R13 short length clamp", act_clks, 6);
        word_len = 6'd40; zero_counts();
        tb_bit(1'b1); idle(36);
        check(act_clks == 64, "R13 long length clamp", act_clks, 64);
        word_len = 6'd8;

        phase = "R5";
        tb_bit(1'b1); tb_bit(1'b1); idle(10);
        check(sync_err == 1'b1, "R5 wide sync error", sync_err, 1);
        phase = "R11"; clear_flags();
        check(sync_err == 1'b0, "R11 clear", sync_err, 0);

        phase = "R7"; err_relax = 1'b1;
        tb_bit(1'b1); tb_bit(1'b1); tb_bit(1'b1); idle(10);
        late_sync = 1'b1;
        tb_bit(1'b1); tb_bit(1'b1); idle(10);
        check(sync_err == 1'b0, "R7 relaxed wide/late", sync_err, 0);
        err_relax = 1'b0;

        phase = "R6"; zero_counts();
        for (int i = 0; i < 4; i++) tb_bit(1'b1);
        idle(10);
        check(sync_err == 1'b1, "R6 late sync dropped", sync_err, 1);
        clear_flags();
        for (int i = 0; i < 8; i++) tb_bit(1'b1);
        idle(4);
        check(sync_err == 1'b0, "R6 late sync held", sync_err, 0);
        check(starts == 2, "R6 start count", starts, 2);
        late_sync = 1'b0;

        phase = "R3"; edge_start = 1'b1; port_en = 1'b0;
        tb_bit(1'b1); tb_bit(1'b1);
        port_en = 1'b1; zero_counts();
        for (int i = 0; i < 5; i++) tb_bit(1'b1);
        check(starts == 0, "R3 held sync ignored", starts, 0);
        tb_bit(1'b0); tb_bit(1'b1); idle(10);
        check(starts == 1, "R3 fresh edge starts", starts, 1);

        phase = "R4"; ext_sync = 1'b0; port_en = 1'b0;
        tb_bit(1'b1);
        port_en = 1'b1; zero_counts();
        tb_bit(1'b1); idle(10);
        check(starts == 1, "R4 internal sync ignores edge mode", starts, 1);
        ext_sync = 1'b1; edge_start = 1'b0;

        phase = "R8"; word_len = 6'd16; tx_last_word = 1'b1; zero_counts();
        sync_train(15, 3);
        check(starts == 3, "R8 premature restarts", starts, 3);
        check(sync_err == 1'b1, "R8 premature error", sync_err, 1);
        check(tx_underflow == 1'b1, "R10 underflow raised", tx_underflow, 1);

        phase = "R9"; clear_flags(); drop_premature = 1'b1; zero_counts();
        sync_train(15, 4);
        check(starts == 2, "R9 premature dropped", starts, 2);
        check(act_clks == 64, "R9 word runs full length", act_clks, 64);
        check(sync_err == 1'b1, "R9 premature error", sync_err, 1);

        phase = "R10"; clear_flags(); drop_premature = 1'b0; uf_relax = 1'b1;
        sync_train(15, 3);
        check(tx_underflow == 1'b0, "R10 underflow relaxed", tx_underflow, 0);
        check(sync_err == 1'b1, "R10 error still raised", sync_err, 1);
        uf_relax = 1'b0; tx_last_word = 1'b0;

        phase = "R11"; clear_flags();
        tb_bit(1'b1); idle(14);
        err_clr = 1'b1; tb_bit(1'b1); err_clr = 1'b0;
        idle(20);
        check(sync_err == 1'b1, "R11 violation beats clear", sync_err, 1);
        clear_flags();
        check(sync_err == 1'b0, "R11 clear alone", sync_err, 0);

        phase = "R1"; word_len = 6'd8;
        tb_bit(1'b1); tb_bit(1'b1); idle(2);
        port_en = 1'b0; tb_bit(1'b0);
        check(word_active == 1'b0 && word_start == 1'b0, "R1 disable mid-word",
              int'({word_start, word_active}), 0);
        check(sync_err == 1'b1, "R1 flag held while disabled", sync_err, 1);
        port_en = 1'b1; idle(3);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog [%s]: actual=timeout expected=finish", phase);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule